// File: doc/BRIEF.md
# Accumulator Processor Core

A small stored-program processor built around one accumulator. It steps through fetch, decode and execute phases over and over, taking each instruction word from a synchronous single-port memory, until it runs a halt instruction. Internally it keeps a program counter, an instruction register, a memory address register that drives every memory access, and a memory data register that holds every word read or written.

Each 16-bit instruction word carries a 4-bit opcode in bits [15:12] and a 12-bit cell address in bits [11:0]. The core moves data between memory and the accumulator, does add and subtract against a memory operand, changes memory cells in place (clear, increment, decrement), and compares a cell with the accumulator into a one-hot greater/equal/less condition register. Branches read that register. The memory returns read data one clock after it sees an address, and the core waits for it in its own states.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is held and right after it, halted_o and mem_we_o are low and mem_addr_o is 0. The program counter, accumulator and all three condition flags clear to 0, so the first instruction comes from address 0.
- R2: Opcode values: 0 load, 1 store, 2 clear, 3 add, 4 increment, 5 subtract, 6 decrement, 7 compare, 8 jump, 9 jump-if-greater, 10 jump-if-equal, 11 jump-if-less, 12 jump-if-not-equal, 13 jump-if-greater-or-equal, 14 jump-if-less-or-equal, 15 halt. The address field is bits [11:0].
- R3: Counted from the first clock edge after reset release, these instructions take 7 cycles: load, add, subtract and compare. Store and clear take 5, increment and decrement take 8, and any jump (taken or not) takes 4. A halt raises halted_o 4 cycles after its fetch begins. The program counter advances by exactly one on every fetch.
- R4: Load X puts cell X into the accumulator. Store X writes the accumulator into cell X.
- R5: Add X sets the accumulator to accumulator plus cell X. Subtract X sets it to accumulator minus cell X. Both wrap modulo 2^16.
- R6: Clear X writes 0 to cell X. Increment X and decrement X write cell X plus or minus one, modulo 2^16, back to cell X. None of the three changes the accumulator.
- R7: Compare X sets exactly one flag. Greater is set when cell X is above the accumulator, equal when they match, and less otherwise, all as unsigned values. The accumulator is left unchanged.
- R8: Jump loads the program counter with X unconditionally. Each conditional jump loads X only when its condition holds on the flags (not-equal means the equal flag is clear; greater-or-equal and less-or-equal are the ORs). Otherwise it falls through to the next word.
- R9: Once halt executes, halted_o stays high and mem_we_o stays low until the next reset. Words after the halt are never executed.
- R10: Every memory write lasts one cycle, goes to the address field of the current instruction, and leaves every other cell untouched.
- R11: Before any compare after reset, conditions that need a set flag are false and jump-if-not-equal is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 12 | Memory address, driven from the address register |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 16 | Memory write data, driven from the data register |
| mem_rdata_i | input | 16 | Memory read data, valid one clock after the address |
| halted_o | output | 1 | High once a halt instruction has executed |

## Verification
The bench goes after the edges of each behaviour. Add and subtract wrap through 0xFFFF. Increment and decrement wrap through zero, and would spill into the accumulator if their result went to the wrong register. The flags are clear before the first compare, so a core that did not reset them would take a branch it should skip. Each conditional jump is tried against all three compare outcomes, which exposes a swapped operand order or a wrong OR of flags as a wrong write pattern. Cycle counts per program expose a missing or extra wait state. Any write after halt, or a halt that is not sticky, shows up in the cycles watched after it.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 4'd0,  OP_STORE = 4'd1,  OP_CLEAR = 4'd2,  OP_ADD   = 4'd3,
    OP_INC   = 4'd4,  OP_SUB   = 4'd5,  OP_DEC   = 4'd6,  OP_CMP   = 4'd7,
    OP_JMP   = 4'd8,  OP_JGT   = 4'd9,  OP_JEQ   = 4'd10, OP_JLT   = 4'd11,
    OP_JNE   = 4'd12, OP_JGE   = 4'd13, OP_JLE   = 4'd14, OP_HALT  = 4'd15
  } opcode_e;

  typedef enum logic [3:0] {
    S_FETCH, S_FWAIT, S_FLOAD, S_DECODE,
    S_RWAIT, S_RLOAD, S_EXEC, S_WRITE, S_HALT
  } state_e;

  typedef enum logic [2:0] {
    ALU_OPND, ALU_ACC, ALU_ZERO, ALU_ADD, ALU_SUB, ALU_INC, ALU_DEC
  } alu_op_e;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } flags_t;

  typedef struct packed {
    logic    rd_mem;
    logic    wr_mem;
    logic    wr_acc;
    logic    set_flags;
    logic    jump;
    logic    halt;
    alu_op_e alu_op;
  } ctl_t;

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
(
  input  opcode_e op_i,
  output ctl_t    ctl_o
);

  always_comb begin
    ctl_o        = '0;
    ctl_o.alu_op = ALU_OPND;
    case (op_i)
      OP_LOAD:  begin ctl_o.rd_mem = 1'b1; ctl_o.wr_acc = 1'b1; ctl_o.alu_op = ALU_OPND; end
      OP_STORE: begin ctl_o.wr_mem = 1'b1; ctl_o.alu_op = ALU_ACC; end
      OP_CLEAR: begin ctl_o.wr_mem = 1'b1; ctl_o.alu_op = ALU_ZERO; end
      OP_ADD:   begin ctl_o.rd_mem = 1'b1; ctl_o.wr_acc = 1'b1; ctl_o.alu_op = ALU_ADD; end
      OP_SUB:   begin ctl_o.rd_mem = 1'b1; ctl_o.wr_acc = 1'b1; ctl_o.alu_op = ALU_SUB; end
      OP_INC:   begin ctl_o.rd_mem = 1'b1; ctl_o.wr_mem = 1'b1; ctl_o.alu_op = ALU_INC; end
      OP_DEC:   begin ctl_o.rd_mem = 1'b1; ctl_o.wr_mem = 1'b1; ctl_o.alu_op = ALU_DEC; end
      OP_CMP:   begin ctl_o.rd_mem = 1'b1; ctl_o.set_flags = 1'b1; end
      OP_JMP, OP_JGT, OP_JEQ, OP_JLT, OP_JNE, OP_JGE, OP_JLE:
                ctl_o.jump = 1'b1;
      OP_HALT:  ctl_o.halt = 1'b1;
      default:  ctl_o.halt = 1'b1;
    endcase
  end

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flags_o
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  always_comb begin
    case (op_i)
      ALU_OPND: res_o = opnd_i;
      ALU_ACC:  res_o = acc_i;
      ALU_ZERO: res_o = '0;
      ALU_ADD:  res_o = acc_i + opnd_i;
      ALU_SUB:  res_o = acc_i - opnd_i;
      ALU_INC:  res_o = opnd_i + ONE;
      ALU_DEC:  res_o = opnd_i - ONE;
      default:  res_o = '0;
    endcase
  end

  // operand in memory is compared against the accumulator, unsigned
  assign flags_o.gt = opnd_i >  acc_i;
  assign flags_o.eq = opnd_i == acc_i;
  assign flags_o.lt = opnd_i <  acc_i;

endmodule

// File: rtl/acc_cpu_branch.sv
module acc_cpu_branch
  import acc_cpu_pkg::*;
(
  input  opcode_e op_i,
  input  flags_t  flags_i,
  output logic    take_o
);

  always_comb begin
    case (op_i)
      OP_JMP:  take_o = 1'b1;
      OP_JGT:  take_o = flags_i.gt;
      OP_JEQ:  take_o = flags_i.eq;
      OP_JLT:  take_o = flags_i.lt;
      OP_JNE:  take_o = ~flags_i.eq;
      OP_JGE:  take_o = flags_i.gt | flags_i.eq;
      OP_JLE:  take_o = flags_i.lt | flags_i.eq;
      default: take_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              halted_o
);

  localparam int unsigned OPC_LSB = DATA_W - OP_W;

  state_e            state_q;
  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] mar_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] mdr_q;
  logic [DATA_W-1:0] acc_q;
  flags_t            flags_q;

  opcode_e           opcode;
  logic [ADDR_W-1:0] addr_field;
  ctl_t              ctl;
  logic [DATA_W-1:0] alu_res;
  flags_t            flags_nxt;
  logic              take;

  assign opcode     = opcode_e'(ir_q[DATA_W-1:OPC_LSB]);
  assign addr_field = ir_q[ADDR_W-1:0];

  acc_cpu_decode u_decode (
    .op_i  (opcode),
    .ctl_o (ctl)
  );

  acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i    (ctl.alu_op),
    .acc_i   (acc_q),
    .opnd_i  (mdr_q),
    .res_o   (alu_res),
    .flags_o (flags_nxt)
  );

  acc_cpu_branch u_branch (
    .op_i    (opcode),
    .flags_i (flags_q),
    .take_o  (take)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_FETCH;
      pc_q    <= '0;
      mar_q   <= '0;
      ir_q    <= '0;
      mdr_q   <= '0;
      acc_q   <= '0;
      flags_q <= '0;
    end else begin
      case (state_q)
        S_FETCH: begin
          mar_q   <= pc_q;
          state_q <= S_FWAIT;
        end
        S_FWAIT: state_q <= S_FLOAD;
        S_FLOAD: begin
          mdr_q   <= mem_rdata_i;
          ir_q    <= mem_rdata_i;
          pc_q    <= pc_q + ADDR_W'(1);
          state_q <= S_DECODE;
        end
        S_DECODE: begin
          mar_q <= addr_field;
          if (ctl.halt) begin
            state_q <= S_HALT;
          end else if (ctl.jump) begin
            if (take) pc_q <= addr_field;
            state_q <= S_FETCH;
          end else if (ctl.rd_mem) begin
            state_q <= S_RWAIT;
          end else begin
            // store / clear: result goes straight to the data register
            mdr_q   <= alu_res;
            state_q <= S_WRITE;
          end
        end
        S_RWAIT: state_q <= S_RLOAD;
        S_RLOAD: begin
          mdr_q   <= mem_rdata_i;
          state_q <= S_EXEC;
        end
        S_EXEC: begin
          if (ctl.wr_acc)    acc_q   <= alu_res;
          if (ctl.set_flags) flags_q <= flags_nxt;
          if (ctl.wr_mem) begin
            mdr_q   <= alu_res;
            state_q <= S_WRITE;
          end else begin
            state_q <= S_FETCH;
          end
        end
        S_WRITE: state_q <= S_FETCH;
        S_HALT:  state_q <= S_HALT;
        default: state_q <= S_HALT;
      endcase
    end
  end

  assign mem_addr_o  = mar_q;
  assign mem_we_o    = (state_q == S_WRITE);
  assign mem_wdata_o = mdr_q;
  assign halted_o    = (state_q == S_HALT);

endmodule

// File: rtl/acc_cpu_core_chk.sv
module acc_cpu_core_chk
  import acc_cpu_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              halted_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input state_e            state_q,
  input logic [ADDR_W-1:0] pc_q,
  input logic [DATA_W-1:0] ir_q,
  input flags_t            flags_q
);

  logic is_cmp;
  assign is_cmp = (opcode_e'(ir_q[DATA_W-1 -: OP_W]) == OP_CMP);

  assert_halt_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  assert_no_write_halted_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !mem_we_o);

  assert_write_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  assert_write_addr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o == ir_q[ADDR_W-1:0]));

  assert_pc_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FLOAD) |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1)));

  assert_cmp_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_EXEC && is_cmp) |=> ($countones(flags_q) == 1));

  assert_flags_onehot0_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flags_q));

endmodule

bind acc_cpu_core acc_cpu_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .halted_o   (halted_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .state_q    (state_q),
  .pc_q       (pc_q),
  .ir_q       (ir_q),
  .flags_q    (flags_q)
);

// File: tb/acc_cpu_core_tb.sv
module acc_cpu_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 12;
  localparam int DATA_W     = 16;
  localparam int MEM_N      = 1 << ADDR_W;
  localparam int DBASE      = 'h100;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_we;
  logic [DATA_W-1:0] mem_wdata;
  logic [DATA_W-1:0] mem_rdata;
  logic              halted;

  logic [DATA_W-1:0] mem     [MEM_N];
  logic [DATA_W-1:0] ref_mem [MEM_N];

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  acc_cpu_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mem_addr_o  (mem_addr),
    .mem_we_o    (mem_we),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .halted_o    (halted)
  );

  function automatic logic [15:0] ins(input int op, input int a);
    return {op[3:0], a[11:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < MEM_N; i++) mem[i] = '0;
  endtask

  // instruction-level model built from the requirements
  task automatic ref_run(output int cyc);
    int pc;
    logic [15:0] acc, w, x;
    logic [3:0] op;
    logic [11:0] a;
    bit gt, eq, lt, tk;
    pc = 0; acc = '0; gt = 0; eq = 0; lt = 0; cyc = 0;
    for (int n = 0; n < 10000; n++) begin
      w  = ref_mem[pc];
      op = w[15:12];
      a  = w[11:0];
      pc = (pc + 1) % MEM_N;
      x  = ref_mem[a];
      if (op == 15) begin cyc += 4; break; end
      case (op)
        0: begin acc = x; cyc += 7; end
        1: begin ref_mem[a] = acc; cyc += 5; end
        2: begin ref_mem[a] = '0; cyc += 5; end
        3: begin acc = acc + x; cyc += 7; end
        4: begin ref_mem[a] = x + 16'd1; cyc += 8; end
        5: begin acc = acc - x; cyc += 7; end
        6: begin ref_mem[a] = x - 16'd1; cyc += 8; end
        7: begin gt = (x > acc); eq = (x == acc); lt = (x < acc); cyc += 7; end
        default: begin
          case (op)
            8:  tk = 1;
            9:  tk = gt;
            10: tk = eq;
            11: tk = lt;
            12: tk = !eq;
            13: tk = gt | eq;
            default: tk = lt | eq;
          endcase
          if (tk) pc = int'(a);
          cyc += 4;
        end
      endcase
    end
  endtask

  task automatic run_prog(input string tag);
    int exp_cyc, cyc, viol, bad;
    for (int i = 0; i < MEM_N; i++) ref_mem[i] = mem[i];
    ref_run(exp_cyc);
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 halted in reset", 32'(halted), 0);
    chk("R1 we in reset", 32'(mem_we), 0);
    chk("R1 addr in reset", 32'(mem_addr), 0);
    rst_ni = 1'b1;
    cyc = 0;
    while (!halted && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R9 halted reached", 32'(halted), 1);
    chk("R3 cycles to halt", 32'(cyc), 32'(exp_cyc));
    viol = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (mem_we || !halted) viol++;
    end
    chk("R9 quiet after halt", 32'(viol), 0);
    bad = 0;
    for (int i = 0; i < MEM_N; i++) if (mem[i] !== ref_mem[i]) bad++;
    chk({tag, " memory image"}, 32'(bad), 0);
  endtask

  function automatic bit exp_take(input int op, input int rel);
    // rel: 0 cell above acc, 1 equal, 2 below
    case (op)
      8:  return 1;
      9:  return rel == 0;
      10: return rel == 1;
      11: return rel == 2;
      12: return rel != 1;
      13: return rel != 2;
      default: return rel != 0;
    endcase
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog actual=expired expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);

    // R4 R5: load/store, add and subtract with wraparound
    clear_mem();
    mem[DBASE]   = 16'hFFFF; mem[DBASE+1] = 16'd2; mem[DBASE+2] = 16'd3;
    mem[0] = ins(0, DBASE);   mem[1] = ins(1, DBASE+'h12);
    mem[2] = ins(3, DBASE+1); mem[3] = ins(1, DBASE+'h10);
    mem[4] = ins(5, DBASE+2); mem[5] = ins(1, DBASE+'h11);
    mem[6] = ins(15, 0);
    run_prog("R10 arith");
    chk("R4 stored load", 32'(mem[DBASE+'h12]), 32'h0000FFFF);
    chk("R5 add wraps", 32'(mem[DBASE+'h10]), 32'h1);
    chk("R5 sub wraps", 32'(mem[DBASE+'h11]), 32'hFFFE);

    // R6: in-place cell ops leave the accumulator alone
    clear_mem();
    mem[DBASE] = 16'd5; mem[DBASE+1] = 16'hFFFF; mem[DBASE+2] = 16'h0; mem[DBASE+3] = 16'h1234;
    mem[0] = ins(0, DBASE);   mem[1] = ins(4, DBASE+1);
    mem[2] = ins(6, DBASE+2); mem[3] = ins(2, DBASE+3);
    mem[4] = ins(1, DBASE+'h10); mem[5] = ins(15, 0);
    run_prog("R10 cell ops");
    chk("R6 inc wraps", 32'(mem[DBASE+1]), 32'h0);
    chk("R6 dec wraps", 32'(mem[DBASE+2]), 32'hFFFF);
    chk("R6 clear", 32'(mem[DBASE+3]), 32'h0);
    chk("R6 acc kept", 32'(mem[DBASE+'h10]), 32'h5);

    // R7 R8: every jump against every compare outcome
    for (int rel = 0; rel < 3; rel++) begin
      for (int op = 8; op <= 14; op++) begin
        clear_mem();
        mem[DBASE] = 16'd5; mem[DBASE+1] = 16'(6 - rel); mem[DBASE+'h10] = 16'hAAAA;
        mem[0] = ins(0, DBASE); mem[1] = ins(7, DBASE+1); mem[2] = ins(op, 4);
        mem[3] = ins(1, DBASE+'h10); mem[4] = ins(1, DBASE+'h11); mem[5] = ins(15, 0);
        run_prog("R8 branch");
        chk("R8 take or fall through", 32'(mem[DBASE+'h10]),
            exp_take(op, rel) ? 32'hAAAA : 32'h5);
        chk("R7 compare keeps acc", 32'(mem[DBASE+'h11]), 32'h5);
      end
    end

    // R11: flags are clear before any compare
    for (int op = 9; op <= 14; op++) begin
      clear_mem();
      mem[DBASE+'h10] = 16'hAAAA;
      mem[0] = ins(op, 2); mem[1] = ins(1, DBASE+'h10); mem[2] = ins(15, 0);
      run_prog("R11 reset flags");
      chk("R11 branch before compare", 32'(mem[DBASE+'h10]),
          (op == 12) ? 32'hAAAA : 32'h0);
    end

    // R9: words past a halt never run
    clear_mem();
    mem[DBASE] = 16'h7777;
    mem[0] = ins(15, 0); mem[1] = ins(2, DBASE);
    run_prog("R9 halt first");
    chk("R9 code after halt skipped", 32'(mem[DBASE]), 32'h7777);

    // R2: random forward-branching programs against the model
    for (int p = 0; p < 40; p++) begin
      int n;
      clear_mem();
      n = 8 + int'($urandom_range(0, 20));
      for (int d = 0; d < 16; d++)
        mem[DBASE+d] = ($urandom_range(0, 1) == 1) ? 16'($urandom_range(0, 3)) : 16'($urandom);
      for (int i = 0; i < n; i++) begin
        int op;
        op = int'($urandom_range(0, 14));
        if (op >= 8) mem[i] = ins(op, int'($urandom_range(i + 1, n)));
        else         mem[i] = ins(op, DBASE + int'($urandom_range(0, 15)));
      end
      mem[n] = ins(15, 0);
      run_prog("R2 random program");
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule